// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Controller

This block sequences a small accumulator machine through its instruction cycle using fixed decode logic rather than a microcode store. A 2-bit phase register records whether the machine is fetching, resolving an indirect address, executing, or servicing an interrupt. A step counter runs through the timing states of each phase. The control word for every clock is decoded from three inputs: the phase, the step, and the one-hot opcode lines. That control word drives the load enables of the program counter (PC), memory address register (MAR), memory buffer register (MBR) and instruction register (IR), and it drives the memory read and write strobes.

Instruction words are 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the operand address. The memory port is synchronous: read data appears on the clock after the read strobe. A branch-and-save instruction writes its return address into the target word and continues at the word that follows. Interrupts are taken between instructions. They save the PC to a fixed location and jump to a fixed service address.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets PC, accumulator and interrupt enable to 0, `cycle_code` to 2'b00 and `t_step` to 0.
- R2: Fetch takes four steps, with `reg_ld` bits {IR,MBR,MAR,PC} = bits 3..0. Step 0 loads MAR from PC (`reg_ld`=0010). Step 1 asserts `mem_rd` and increments PC (0001). Step 2 loads MBR from memory (0100). Step 3 loads IR from MBR (1000).
- R3: `cycle_code` is 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. After fetch, the next phase is indirect when bit 15 of the fetched word is set, otherwise execute.
- R4: The indirect phase reads the word at the operand address and replaces the operand address with its low 12 bits, then continues to execute.
- R5: The opcodes are load 000 (AC=M[a]), add 001 (AC=AC+M[a]) and store 010 (M[a]=AC).
- R6: Jump 011 sets PC to the operand address. Jump-if-zero 100 does the same only when AC is zero and otherwise leaves PC unchanged.
- R7: Branch-and-save 101 to address X writes the address of the following instruction into X and resumes at X+1.
- R8: Opcode 110 sets interrupt enable and opcode 111 does nothing. When an execute phase ends, the interrupt phase follows if `irq` is high and interrupt enable was already set before that instruction; otherwise fetch follows.
- R9: The interrupt phase writes PC to SAVE_ADDR (default 0x0F0), sets PC to ISR_ADDR (default 0x0F1), clears interrupt enable and returns to fetch.
- R10: No step loads more than one of PC, MAR, MBR and IR. No step both reads and writes memory. `t_step` is 0 in the first cycle of every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rdata | input | 16 | Memory read data, valid one clock after `mem_rd` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| cycle_code | output | 2 | Current phase code |
| t_step | output | 2 | Timing state within the phase (0 = first) |
| reg_ld | output | 4 | Load enables {IR,MBR,MAR,PC} |
| pc_out | output | 12 | Program counter |
| ac_out | output | 16 | Accumulator |
| ien_out | output | 1 | Interrupt enable |

## Verification
The test program covers every opcode, including both the taken and the not-taken outcome of jump-if-zero. Direct and indirect operands are mixed so that the operand path is checked both ways. Because `irq` is held high for the whole run, the program shows three things: no interrupt is taken while enable is off, the entry is delayed by one instruction after enabling, and the service routine cannot be re-entered. The order of fetch addresses tells control-flow errors apart from data errors. The write stream of address and data pairs exposes a wrong return address, a wrong save location and wrong arithmetic.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_ADD   = 3'd1,
    OP_STORE = 3'd2,
    OP_JUMP  = 3'd3,
    OP_JZ    = 3'd4,
    OP_CALL  = 3'd5,
    OP_INTON = 3'd6,
    OP_NOP   = 3'd7
  } op_e;

  typedef enum logic [1:0] {MA_PC, MA_IR, MA_SAVE} mar_src_e;
  typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_IR, PC_MARP1, PC_ISR} pc_op_e;
  typedef enum logic [1:0] {MB_MEM, MB_AC, MB_PC} mbr_src_e;
  typedef enum logic [1:0] {AC_HOLD, AC_LOAD, AC_ADD} ac_op_e;

  typedef struct packed {
    logic     mar_ld;
    mar_src_e mar_src;
    pc_op_e   pc_op;
    logic     mbr_ld;
    mbr_src_e mbr_src;
    logic     ir_ld;
    logic     ir_addr_ld;
    ac_op_e   ac_op;
    logic     ien_set;
    logic     ien_clr;
  } dp_ctrl_t;

  typedef struct packed {
    dp_ctrl_t dp;
    logic     mem_rd;
    logic     mem_wr;
    logic     last;
  } ctrl_t;

endpackage

// File: rtl/icc_line_decoder.sv
module icc_line_decoder #(
  parameter int N = 3
) (
  input  logic [N-1:0]      code,
  output logic [2**N-1:0]   lines
);
  localparam int L = 2**N;

  for (genvar i = 0; i < L; i++) begin : g_line
    assign lines[i] = (code == N'(i));
  end
endmodule

// File: rtl/icc_step_timer.sv
module icc_step_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_end,
  output logic [TW-1:0] step
);
  always_ff @(posedge clk) begin
    if (rst || phase_end) step <= '0;
    else                  step <= step + TW'(1);
  end
endmodule

// File: rtl/icc_ctrl_logic.sv
module icc_ctrl_logic
  import icc_pkg::*;
#(
  parameter int TW  = 2,
  parameter int OPW = 3
) (
  input  phase_e             phase,
  input  logic [2**TW-1:0]   t_line,
  input  logic [2**OPW-1:0]  op_line,
  input  logic               ac_zero,
  output ctrl_t              c
);
  logic mem_in;
  assign mem_in = op_line[OP_LOAD] | op_line[OP_ADD];

  always_comb begin
    c = '0;
    unique case (phase)
      PH_FETCH: begin
        if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_PC; end
        if (t_line[1]) begin c.mem_rd = 1'b1; c.dp.pc_op = PC_INC; end
        if (t_line[2]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_MEM; end
        if (t_line[3]) begin c.dp.ir_ld = 1'b1; c.last = 1'b1; end
      end
      PH_INDIR: begin
        if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_IR; end
        if (t_line[1]) c.mem_rd = 1'b1;
        if (t_line[2]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_MEM; end
        if (t_line[3]) begin c.dp.ir_addr_ld = 1'b1; c.last = 1'b1; end
      end
      PH_EXEC: begin
        if (mem_in) begin
          if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_IR; end
          if (t_line[1]) c.mem_rd = 1'b1;
          if (t_line[2]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_MEM; end
          if (t_line[3]) begin
            c.dp.ac_op = op_line[OP_ADD] ? AC_ADD : AC_LOAD;
            c.last     = 1'b1;
          end
        end
        if (op_line[OP_STORE]) begin
          if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_IR; end
          if (t_line[1]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_AC; end
          if (t_line[2]) begin c.mem_wr = 1'b1; c.last = 1'b1; end
        end
        if (op_line[OP_JUMP] && t_line[0]) begin
          c.dp.pc_op = PC_IR;
          c.last     = 1'b1;
        end
        if (op_line[OP_JZ] && t_line[0]) begin
          c.dp.pc_op = ac_zero ? PC_IR : PC_HOLD;
          c.last     = 1'b1;
        end
        if (op_line[OP_CALL]) begin
          if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_IR; end
          if (t_line[1]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_PC; end
          if (t_line[2]) begin
            c.mem_wr   = 1'b1;
            c.dp.pc_op = PC_MARP1;
            c.last     = 1'b1;
          end
        end
        if (op_line[OP_INTON] && t_line[0]) begin
          c.dp.ien_set = 1'b1;
          c.last       = 1'b1;
        end
        if (op_line[OP_NOP] && t_line[0]) c.last = 1'b1;
      end
      PH_INTR: begin
        if (t_line[0]) begin c.dp.mar_ld = 1'b1; c.dp.mar_src = MA_SAVE; end
        if (t_line[1]) begin c.dp.mbr_ld = 1'b1; c.dp.mbr_src = MB_PC; end
        if (t_line[2]) begin
          c.mem_wr     = 1'b1;
          c.dp.pc_op   = PC_ISR;
          c.dp.ien_clr = 1'b1;
          c.last       = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/icc_datapath.sv
module icc_datapath
  import icc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 12,
  parameter int OPW       = 3,
  parameter int SAVE_ADDR = 'h0F0,
  parameter int ISR_ADDR  = 'h0F1
) (
  input  logic           clk,
  input  logic           rst,
  input  dp_ctrl_t       c,
  input  logic [DW-1:0]  mem_rdata,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  mar,
  output logic [DW-1:0]  mbr,
  output logic [DW-1:0]  ac,
  output logic           ien,
  output logic           ir_ind,
  output logic [OPW-1:0] ir_op
);
  localparam int PADW = DW - AW;

  logic [DW-1:0] ir;
  logic [AW-1:0] ir_addr;

  assign ir_ind  = ir[DW-1];
  assign ir_op   = ir[DW-2 -: OPW];
  assign ir_addr = ir[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
      ien <= 1'b0;
    end else begin
      if (c.mar_ld) begin
        unique case (c.mar_src)
          MA_PC:   mar <= pc;
          MA_IR:   mar <= ir_addr;
          default: mar <= AW'(SAVE_ADDR);
        endcase
      end
      unique case (c.pc_op)
        PC_INC:   pc <= pc + AW'(1);
        PC_IR:    pc <= ir_addr;
        PC_MARP1: pc <= mar + AW'(1);
        PC_ISR:   pc <= AW'(ISR_ADDR);
        default:  ;
      endcase
      if (c.mbr_ld) begin
        unique case (c.mbr_src)
          MB_MEM:  mbr <= mem_rdata;
          MB_AC:   mbr <= ac;
          default: mbr <= {{PADW{1'b0}}, pc};
        endcase
      end
      if (c.ir_ld)           ir          <= mbr;
      else if (c.ir_addr_ld) ir[AW-1:0]  <= mbr[AW-1:0];
      unique case (c.ac_op)
        AC_LOAD: ac <= mbr;
        AC_ADD:  ac <= ac + mbr;
        default: ;
      endcase
      if (c.ien_clr)      ien <= 1'b0;
      else if (c.ien_set) ien <= 1'b1;
    end
  end

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (c.pc_op == PC_INC) |=> (pc == $past(pc) + AW'(1)));

  assert_ien_drop_R9: assert property (@(posedge clk) disable iff (rst)
    c.ien_clr |=> !ien);

  assert_ien_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (c.ien_set && !c.ien_clr) |=> ien);
endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 12,
  parameter int TW        = 2,
  parameter int SAVE_ADDR = 'h0F0,
  parameter int ISR_ADDR  = 'h0F1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [1:0]    cycle_code,
  output logic [TW-1:0] t_step,
  output logic [3:0]    reg_ld,
  output logic [AW-1:0] pc_out,
  output logic [DW-1:0] ac_out,
  output logic          ien_out
);
  localparam int OPW = $bits(op_e);
  localparam int NOP_LINES = 2**OPW;
  localparam int NT_LINES  = 2**TW;

  phase_e                 cyc_q, cyc_d;
  ctrl_t                  c;
  logic [TW-1:0]          step;
  logic [NT_LINES-1:0]    t_line;
  logic [NOP_LINES-1:0]   op_line;
  logic [OPW-1:0]         ir_op;
  logic                   ir_ind;
  logic [AW-1:0]          pc, mar;
  logic [DW-1:0]          mbr, ac;
  logic                   ien;

  icc_step_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .phase_end(c.last), .step(step)
  );

  icc_line_decoder #(.N(TW)) u_tdec (.code(step), .lines(t_line));
  icc_line_decoder #(.N(OPW)) u_opdec (.code(ir_op), .lines(op_line));

  icc_ctrl_logic #(.TW(TW), .OPW(OPW)) u_ctrl (
    .phase(cyc_q), .t_line(t_line), .op_line(op_line),
    .ac_zero(ac == '0), .c(c)
  );

  icc_datapath #(
    .DW(DW), .AW(AW), .OPW(OPW), .SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)
  ) u_dp (
    .clk(clk), .rst(rst), .c(c.dp), .mem_rdata(mem_rdata),
    .pc(pc), .mar(mar), .mbr(mbr), .ac(ac), .ien(ien),
    .ir_ind(ir_ind), .ir_op(ir_op)
  );

  always_comb begin
    cyc_d = cyc_q;
    if (c.last) begin
      unique case (cyc_q)
        PH_FETCH: cyc_d = mbr[DW-1] ? PH_INDIR : PH_EXEC;
        PH_INDIR: cyc_d = PH_EXEC;
        PH_EXEC:  cyc_d = (ien && irq) ? PH_INTR : PH_FETCH;
        default:  cyc_d = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= PH_FETCH;
    else     cyc_q <= cyc_d;
  end

  assign mem_addr   = mar;
  assign mem_wdata  = mbr;
  assign mem_rd     = c.mem_rd;
  assign mem_wr     = c.mem_wr;
  assign cycle_code = cyc_q;
  assign t_step     = step;
  assign reg_ld     = {c.dp.ir_ld | c.dp.ir_addr_ld, c.dp.mbr_ld, c.dp.mar_ld,
                       c.dp.pc_op != PC_HOLD};
  assign pc_out     = pc;
  assign ac_out     = ac;
  assign ien_out    = ien;

  assert_single_load_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reg_ld));

  assert_no_rw_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_phase_t1_R10: assert property (@(posedge clk) disable iff (rst)
    (cycle_code != $past(cycle_code)) |-> (t_step == '0));

  assert_fetch_route_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == PH_FETCH && c.last) |=>
      (cycle_code == (ir_ind ? 2'b01 : 2'b10)));

  assert_call_resume_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == PH_EXEC && op_line[OP_CALL] && c.last) |=>
      (pc == $past(mar) + AW'(1)));

  assert_irq_entry_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == PH_EXEC && c.last && ien && irq) |=> (cycle_code == 2'b11));

  assert_irq_save_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc_q == PH_INTR && mem_wr) |-> (mem_addr == AW'(SAVE_ADDR)));
endmodule

// File: tb/instr_cycle_ctrl_test.sv
module instr_cycle_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int TW = 2;
  localparam int MW = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_rd, mem_wr;
  logic [1:0]    cycle_code;
  logic [TW-1:0] t_step;
  logic [3:0]    reg_ld;
  logic [AW-1:0] pc_out;
  logic [DW-1:0] ac_out;
  logic          ien_out;

  always #5 clk = ~clk;

  instr_cycle_ctrl uut (
    .clk(clk), .rst(rst), .irq(irq), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .cycle_code(cycle_code), .t_step(t_step),
    .reg_ld(reg_ld), .pc_out(pc_out), .ac_out(ac_out), .ien_out(ien_out)
  );

  logic [DW-1:0] mem [MW];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[8:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
  end

  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  exp_t fetch_q[$];
  exp_t wr_q[$];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int ind_cnt = 0, int_cnt = 0, viol = 0;
  logic [1:0] prev_cc = 2'b00;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input bit ind, input int op, input int a);
    return {ind, 3'(op), 12'(a)};
  endfunction

  task automatic push_fetch(input int a, input string req);
    exp_t e;
    e.a = AW'(a); e.d = '0; e.req = req;
    fetch_q.push_back(e);
  endtask

  task automatic push_wr(input int a, input int d, input string req);
    exp_t e;
    e.a = AW'(a); e.d = DW'(d); e.req = req;
    wr_q.push_back(e);
  endtask

  // driver: program image and the expected fetch and write streams
  task automatic load_program();
    for (int i = 0; i < MW; i++) mem[i] = '0;
    mem['h000] = enc(0, 0, 'h100);   // load
    mem['h001] = enc(1, 1, 'h101);   // add, indirect
    mem['h002] = enc(0, 2, 'h103);   // store
    mem['h003] = enc(0, 4, 'h020);   // jz, not taken
    mem['h004] = enc(0, 5, 'h030);   // branch-and-save
    mem['h031] = enc(0, 0, 'h104);   // load zero
    mem['h032] = enc(0, 4, 'h040);   // jz, taken
    mem['h040] = enc(0, 2, 'h105);   // store
    mem['h041] = enc(1, 3, 'h106);   // jump, indirect
    mem['h050] = enc(0, 6, 0);       // interrupt enable
    mem['h051] = enc(0, 7, 0);       // nop
    mem['h0F1] = enc(0, 0, 'h107);
    mem['h0F2] = enc(0, 2, 'h108);
    mem['h0F3] = enc(0, 3, 'h0F3);   // idle loop
    mem['h100] = 16'h0005;
    mem['h101] = 16'h0102;
    mem['h102] = 16'h0007;
    mem['h104] = 16'h0000;
    mem['h106] = 16'h0050;
    mem['h107] = 16'h1234;
    push_fetch('h000, "R1"); push_fetch('h001, "R2"); push_fetch('h002, "R2");
    push_fetch('h003, "R5"); push_fetch('h004, "R6"); push_fetch('h031, "R7");
    push_fetch('h032, "R5"); push_fetch('h040, "R6"); push_fetch('h041, "R5");
    push_fetch('h050, "R4"); push_fetch('h051, "R8"); push_fetch('h0F1, "R9");
    push_fetch('h0F2, "R5"); push_fetch('h0F3, "R5"); push_fetch('h0F3, "R9");
    push_wr('h103, 'h000C, "R4");
    push_wr('h030, 'h0005, "R7");
    push_wr('h105, 'h0000, "R5");
    push_wr('h0F0, 'h0052, "R9");
    push_wr('h108, 'h1234, "R5");
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      logic [3:0] exp_ld;
      cyc++;
      if (!$onehot0(reg_ld) || (mem_rd && mem_wr)) viol++;
      if (cycle_code != prev_cc && t_step != 0) viol++;
      prev_cc = cycle_code;
      if (cycle_code == 2'b01 && t_step == 0) ind_cnt++;
      if (cycle_code == 2'b11 && t_step == 0) int_cnt++;
      if (cycle_code == 2'b00) begin
        case (t_step)
          2'd0:    exp_ld = 4'b0010;
          2'd1:    exp_ld = 4'b0001;
          2'd2:    exp_ld = 4'b0100;
          default: exp_ld = 4'b1000;
        endcase
        check(reg_ld == exp_ld && mem_rd == (t_step == 2'd1), "R2",
              "fetch step enables", {27'd0, mem_rd, reg_ld}, {27'd0, t_step == 2'd1, exp_ld});
        if (t_step == 2'd1 && fetch_q.size() > 0) begin
          e = fetch_q.pop_front();
          check(mem_addr == e.a, e.req, "fetch address", 32'(mem_addr), 32'(e.a));
        end
      end
      if (mem_wr) begin
        if (wr_q.size() == 0) check(1'b0, "R10", "unexpected write", 32'(mem_addr), 0);
        else begin
          e = wr_q.pop_front();
          check(mem_addr == e.a && mem_wdata == e.d, e.req, "write addr/data",
                {4'd0, mem_addr, mem_wdata}, {4'd0, e.a, e.d});
        end
      end
    end
  end

  initial begin
    load_program();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cycle_code == 2'b00 && t_step == 0, "R1", "reset phase/step",
          {30'd0, cycle_code}, 0);
    check(pc_out == 0 && ac_out == 0 && ien_out == 1'b0, "R1", "reset regs",
          {3'd0, ien_out, pc_out, ac_out}, 0);
    check(reg_ld == 4'b0010 && !mem_rd && !mem_wr, "R1", "reset controls",
          {26'd0, mem_rd, mem_wr, reg_ld}, 32'h2);
    rst = 1'b0;
    irq = 1'b1;
    while (fetch_q.size() > 0 && cyc < 5000) @(negedge clk);
    check(cyc < 5000, "R2", "watchdog", cyc, 5000);
    repeat (40) @(negedge clk);
    check(wr_q.size() == 0, "R9", "all writes seen", wr_q.size(), 0);
    check(ac_out == 16'h1234, "R5", "final accumulator", ac_out, 16'h1234);
    check(ien_out == 1'b0, "R9", "enable cleared", ien_out, 0);
    check(ind_cnt == 2, "R4", "indirect phase count", ind_cnt, 2);
    check(int_cnt == 1, "R8", "interrupt phase count", int_cnt, 1);
    check(viol == 0, "R10", "load/strobe/step rule breaks", viol, 0);
    check(mem['h030] == 16'h0005, "R7", "saved return", mem['h030], 5);
    check(mem['h0F0] == 16'h0052, "R9", "saved pc", mem['h0F0], 'h52);
    check(mem['h103] == 16'h000C, "R3", "indirect add result", mem['h103], 'hC);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(pc_out == 0 && cycle_code == 2'b00 && ac_out == 0, "R1",
          "second reset", {4'd0, pc_out, ac_out}, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule